// File: doc/BRIEF.md
# Prioritized Exception Cause Selector

This block looks at a 16-bit vector of raised exception flags, where bit n stands for the trap cause numbered n. It reports the one cause that the trap logic should take. The reported cause is not the one with the lowest or highest number. It is chosen by a fixed architectural ranking:

- breakpoint first;
- then faults raised while fetching the instruction;
- then illegal instructions and environment calls;
- then misaligned data accesses;
- then data page faults;
- then data access faults.

Within each data group, a store ranks above a load.

A mode input selects which flags are eligible. In full mode every defined cause is eligible. In front-end mode only the causes that fetch and decode can raise are eligible. Bit positions that carry no defined cause are never eligible. The selection is available combinationally in the same cycle. A registered copy of it is also available, one cycle later, for use by a pipeline stage downstream.

Top module: `exc_cause_sel`

## Requirements
- R1: When at least one eligible flag is raised, `pick_valid_o` is 1 and `pick_cause_o` holds the number of a raised, eligible flag in the same cycle.
- R2: When several eligible flags are raised, the cause reported is the first in this ranking: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5. These are, in order: breakpoint; fetch page fault; fetch access fault; illegal instruction; fetch misaligned; environment call from M, from S and from U; store misaligned; load misaligned; store page fault; load page fault; store access fault; load access fault.
- R3: When `fe_only_i` is 1, only flags 0, 1, 2 and 12 are eligible. Every other flag has no effect on the outputs.
- R4: Flags 10 and 14 have no effect on the outputs in either mode.
- R5: When no eligible flag is raised, `pick_valid_o` is 0 and `pick_cause_o` is 0.
- R6: After every rising clock edge, `held_valid_o` and `held_cause_o` equal the values that `pick_valid_o` and `pick_cause_o` had just before that edge.
- R7: While `rst_ni` is 0, `held_valid_o` and `held_cause_o` are 0. The reset is asynchronous and active low.
- R8: In front-end mode the eligible causes rank 12, then 1, then 2, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered copy |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flags_i | input | 16 | Raised exception flags; bit n is cause n |
| fe_only_i | input | 1 | 1 = front-end subset only; 0 = all defined causes |
| pick_valid_o | output | 1 | Combinational: an eligible flag is raised |
| pick_cause_o | output | 4 | Combinational: selected cause number |
| held_valid_o | output | 1 | Registered copy of pick_valid_o |
| held_cause_o | output | 4 | Registered copy of pick_cause_o |

## Verification
The hardest cases to reach are those where the ranking disagrees with numeric order. One example is a high-numbered fetch page fault that must beat a low-numbered illegal instruction. Another is a store fault that must beat a load fault, while a masked or undefined bit sits alongside them. Stimulus reaches these cases in three ways:

- every pair of flags is driven in both modes;
- directed vectors stack the whole front-end subset on top of undefined bits;
- random multi-flag vectors of varying density, from a fixed seed, are compared against a ranking list held in the bench.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int VEC_W      = 16;
    localparam int CAUSE_W    = $clog2(VEC_W);
    localparam int NUM_RANKED = 14;

    // Eligibility masks: all defined causes (10 and 14 undefined), and the fetch/decode subset.
    localparam logic [VEC_W-1:0] ALL_MASK   = 16'hBBFF;
    localparam logic [VEC_W-1:0] FRONT_MASK = 16'h1007;

    // Ranking, highest first.
    localparam logic [CAUSE_W-1:0] RANK_ORDER [NUM_RANKED] = '{
        4'd3, 4'd12, 4'd1, 4'd2, 4'd0, 4'd11, 4'd9,
        4'd8, 4'd6, 4'd4, 4'd15, 4'd13, 4'd7, 4'd5
    };

    typedef enum logic {
        MODE_ALL   = 1'b0,
        MODE_FRONT = 1'b1
    } sel_mode_e;

    typedef struct packed {
        logic               valid;
        logic [CAUSE_W-1:0] cause;
    } pick_t;

endpackage

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
    import exc_sel_pkg::*;
#(
    parameter int               W     = VEC_W,
    parameter logic [W-1:0]     MASK_A = ALL_MASK,
    parameter logic [W-1:0]     MASK_F = FRONT_MASK
) (
    input  logic [W-1:0] raw_i,
    input  sel_mode_e    mode_i,
    output logic [W-1:0] elig_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK_A[b] && MASK_F[b]) begin : g_both
            assign elig_o[b] = raw_i[b];
        end else if (MASK_A[b]) begin : g_full_only
            assign elig_o[b] = raw_i[b] & (mode_i == MODE_ALL);
        end else if (MASK_F[b]) begin : g_front_only
            assign elig_o[b] = raw_i[b] & (mode_i == MODE_FRONT);
        end else begin : g_never
            assign elig_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
    import exc_sel_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int CW = CAUSE_W,
    parameter int NR = NUM_RANKED
) (
    input  logic [W-1:0] elig_i,
    output pick_t        pick_o
);

    // Walk from lowest rank upward so the highest-ranked raised flag is written last.
    always_comb begin
        pick_o = '0;
        for (int r = NR - 1; r >= 0; r--) begin
            if (elig_i[RANK_ORDER[r]]) begin
                pick_o.valid = 1'b1;
                pick_o.cause = RANK_ORDER[r];
            end
        end
    end

endmodule

// File: rtl/exc_pick_reg.sv
module exc_pick_reg
    import exc_sel_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  pick_t d_i,
    output pick_t q_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

    // R6: the held copy is the previous cycle's selection.
    p_held_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> q_o == $past(d_i));

    // R5: a not-valid held value carries cause 0.
    p_held_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q_o.valid |-> q_o.cause == '0);

endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_sel_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [VEC_W-1:0]   flags_i,
    input  logic               fe_only_i,
    output logic               pick_valid_o,
    output logic [CAUSE_W-1:0] pick_cause_o,
    output logic               held_valid_o,
    output logic [CAUSE_W-1:0] held_cause_o
);

    sel_mode_e          mode;
    logic [VEC_W-1:0]   elig;
    pick_t              pick;
    pick_t              held;

    assign mode = fe_only_i ? MODE_FRONT : MODE_ALL;

    exc_mask_filter u_filter (
        .raw_i  (flags_i),
        .mode_i (mode),
        .elig_o (elig)
    );

    exc_rank_pick u_pick (
        .elig_i (elig),
        .pick_o (pick)
    );

    exc_pick_reg u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pick),
        .q_o    (held)
    );

    assign pick_valid_o = pick.valid;
    assign pick_cause_o = pick.cause;
    assign held_valid_o = held.valid;
    assign held_cause_o = held.cause;

    // R1: a reported cause always has its flag raised.
    p_cause_raised_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pick_valid_o |-> flags_i[pick_cause_o]);

    // R3: front-end mode reports only fetch/decode causes.
    p_front_subset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fe_only_i && pick_valid_o) |->
            (pick_cause_o == 4'd0 || pick_cause_o == 4'd1 ||
             pick_cause_o == 4'd2 || pick_cause_o == 4'd12));

    // R4: undefined positions are never reported.
    p_no_undef_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pick_valid_o |-> (pick_cause_o != 4'd10 && pick_cause_o != 4'd14));

    // R5: nothing reported carries cause 0.
    p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pick_valid_o |-> pick_cause_o == '0);

    // R2: a raised breakpoint in full mode always wins.
    p_break_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fe_only_i && flags_i[3]) |-> (pick_valid_o && pick_cause_o == 4'd3));

endmodule

// File: tb/exc_cause_sel_bench.sv
module exc_cause_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] flags = '0;
    logic        fe_only = 1'b0;
    logic        pv, hv;
    logic [3:0]  pc, hc;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    exc_cause_sel u_exc_cause_sel (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .flags_i      (flags),
        .fe_only_i    (fe_only),
        .pick_valid_o (pv),
        .pick_cause_o (pc),
        .held_valid_o (hv),
        .held_cause_o (hc)
    );

    // Bench ranking list, from the requirements (R2).
    int rank_list [14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

    function automatic logic [4:0] ref_pick(logic [15:0] f, logic fe);
        for (int r = 0; r < 14; r++) begin
            int c = rank_list[r];
            bit ok = fe ? (c == 0 || c == 1 || c == 2 || c == 12) : 1'b1;
            if (ok && f[c]) return {1'b1, 4'(c)};
        end
        return 5'd0;
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] f, logic fe, string req);
        logic [4:0] e;
        e = ref_pick(f, fe);
        @(negedge clk);
        flags = f;
        fe_only = fe;
        #1;
        check(req, {pv, pc}, e);
        @(posedge clk);
        #1;
        check("R6", {hv, hc}, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        flags = 16'hFFFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7", {hv, hc}, 5'd0);
        rst_n = 1'b1;

        // Single flags, both modes: R1 / R3 / R4
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 16; b++) begin
                if (b == 10 || b == 14) apply(16'(1) << b, m[0], "R4");
                else if (m == 1)        apply(16'(1) << b, 1'b1, "R3");
                else                    apply(16'(1) << b, 1'b0, "R1");
            end
        end

        // Empty and undefined-only inputs: R5 / R4
        apply(16'h0000, 1'b0, "R5");
        apply(16'h0000, 1'b1, "R5");
        apply(16'h4400, 1'b0, "R4");
        apply(16'h4400, 1'b1, "R4");
        apply(16'hEFF8, 1'b1, "R3");

        // Front-end ordering: R8
        apply(16'h5407, 1'b1, "R8");
        apply(16'h0007, 1'b1, "R8");
        apply(16'h0005, 1'b1, "R8");
        apply(16'h0001, 1'b1, "R8");
        apply(16'h100F, 1'b1, "R8");

        // Exhaustive pairs, both modes: R2
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply((16'(1) << a) | (16'(1) << b), m[0], "R2");

        // Random multi-flag vectors of varying density: R2
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            if (i % 3 == 1) v = v & 16'($urandom);
            if (i % 3 == 2) v = v & 16'($urandom) & 16'($urandom);
            apply(v, 1'($urandom), "R2");
        end

        // Asynchronous reset clears the held copy while a flag is raised: R7
        apply(16'h0008, 1'b0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7", {hv, hc}, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule